// File: doc/BRIEF.md
# Programmable address window decoder

This block keeps a small bank of software-programmed address windows. It translates any 64-bit physical address into the interface ID of the target that owns it. Each window has a 64-bit base, held as two 32-bit halves with no shift, and an attribute word. The attribute word carries an enable flag, an 8-bit target ID and a 6-bit size code. A window spans 2^(size+1) bytes starting at its base.

Software programs the windows through a single-cycle register write port, reads them back through a combinational read port, and clears a whole window with a one-cycle disable strobe. The lookup side is purely combinational. It scans the windows from index 0 upward and reports the first enabled one whose range contains the address, with its index, target ID, base and size code. When no window claims the address, every field is zero and the index is all ones. A 32-bit occupancy mask shows which windows are enabled. Window slots beyond the configured count read as occupied.

Top module: `addr_win_dec`

## Requirements
- R1: While rst_ni is low, every window register reads zero, hit_o is 0, and used_o shows only the slots at or above NUM_WIN as set.
- R2: Register word address reg_addr_i = index*4 + sel, where sel 0 is base bits 63:32, sel 1 is base bits 31:0 and sel 2 is the attribute word. A write takes effect at the next rising clock, and a read returns the last value written. Sel 3, or an index at or above NUM_WIN, reads 0, and writes to it change nothing.
- R3: Attribute bit 31 is the enable. A window with this bit clear never produces a hit.
- R4: On a hit, target_o equals attribute bits 27:20 of the winning window.
- R5: Attribute bits 5:0 are the size code, reported on size_o. An address hits when base <= address < base + 2^(size+1), evaluated without wrap, so a window that reaches 2^64 still excludes address 0.
- R6: The base is the two 32-bit halves concatenated unshifted, and it is reported on base_o.
- R7: When several enabled windows contain the address, the lowest index is reported on idx_o.
- R8: With no hit, hit_o is 0, idx_o is all ones, and target_o, base_o and size_o are all zero.
- R9: A dis_i pulse clears the attribute word and both base halves of window dis_idx_i. A disable outranks a write to the same window in the same cycle.
- R10: used_o bit i equals the enable bit of window i for i < NUM_WIN, and it is 1 for every i >= NUM_WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register word address (index*4 + sel) |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Combinational register read data |
| dis_i | input | 1 | Window disable strobe |
| dis_idx_i | input | 5 | Index of window to disable |
| lk_addr_i | input | 64 | Lookup address |
| hit_o | output | 1 | Lookup matched an enabled window |
| idx_o | output | 5 | Winning window index, all ones on miss |
| target_o | output | 8 | Target interface ID of the winner |
| base_o | output | 64 | Base of the winner |
| size_o | output | 6 | Size code of the winner |
| used_o | output | 32 | Window occupancy mask |

## Verification
The hardest situations to reach are overlapping windows with different enable states, where priority has to skip a disabled lower window, and windows whose end lands exactly on 2^64. Random stimulus draws bases from a tiny pool of 4 KiB-aligned values with small size codes, so windows overlap often, and aims lookups near live window edges. Directed cases then place a window at the top of the address space, use the largest size code, and put a disable and a write in the same cycle.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int MAX_WIN = 32;
  localparam int IDX_W   = 5;
  localparam int RA_W    = IDX_W + 2;
  localparam int TGT_W   = 8;
  localparam int SZ_W    = 6;
  localparam int EN_BIT  = 31;
  localparam int TGT_LSB = 20;

  typedef enum logic [1:0] {
    SEL_BHI  = 2'd0,
    SEL_BLO  = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [TGT_W-1:0] TGT_PCIE1  = 8'h00;
  localparam logic [TGT_W-1:0] TGT_SRIO1  = 8'h08;
  localparam logic [TGT_W-1:0] TGT_DDR1   = 8'h10;
  localparam logic [TGT_W-1:0] TGT_DDR2   = 8'h11;
  localparam logic [TGT_W-1:0] TGT_DDR_IL = 8'h14;
  localparam logic [TGT_W-1:0] TGT_LBUS   = 8'h1f;
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [RA_W-1:0]               reg_addr_i,
  input  logic [31:0]                   wr_data_i,
  output logic [31:0]                   rd_data_o,
  input  logic                          dis_i,
  input  logic [IDX_W-1:0]              dis_idx_i,
  output logic [NUM_WIN-1:0][63:0]      base_o,
  output logic [NUM_WIN-1:0]            en_o,
  output logic [NUM_WIN-1:0][TGT_W-1:0] tgt_o,
  output logic [NUM_WIN-1:0][SZ_W-1:0]  size_o
);
  logic [IDX_W-1:0] sel_idx;
  reg_sel_e         sel;
  logic [NUM_WIN-1:0][31:0] bhi_q, blo_q, attr_q;

  assign sel_idx = reg_addr_i[RA_W-1:2];
  assign sel     = reg_sel_e'(reg_addr_i[1:0]);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bhi_q[i]  <= '0;
        blo_q[i]  <= '0;
        attr_q[i] <= '0;
      end else if (dis_i && dis_idx_i == IDX_W'(i)) begin
        bhi_q[i]  <= '0;
        blo_q[i]  <= '0;
        attr_q[i] <= '0;
      end else if (wr_en_i && sel_idx == IDX_W'(i)) begin
        case (sel)
          SEL_BHI:  bhi_q[i]  <= wr_data_i;
          SEL_BLO:  blo_q[i]  <= wr_data_i;
          SEL_ATTR: attr_q[i] <= wr_data_i;
          default:  ;
        endcase
      end
    end
    assign base_o[i] = {bhi_q[i], blo_q[i]};
    assign en_o[i]   = attr_q[i][EN_BIT];
    assign tgt_o[i]  = attr_q[i][TGT_LSB +: TGT_W];
    assign size_o[i] = attr_q[i][SZ_W-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel_idx == IDX_W'(i)) begin
        case (sel)
          SEL_BHI:  rd_data_o = bhi_q[i];
          SEL_BLO:  rd_data_o = blo_q[i];
          SEL_ATTR: rd_data_o = attr_q[i];
          default:  rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [63:0]                  addr_i,
  input  logic [NUM_WIN-1:0][63:0]     base_i,
  input  logic [NUM_WIN-1:0]           en_i,
  input  logic [NUM_WIN-1:0][SZ_W-1:0] size_i,
  output logic [NUM_WIN-1:0]           hit_vec_o
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    // 65-bit limit so a window ending at 2^64 does not wrap
    logic [64:0] lim;
    assign lim = {1'b0, base_i[i]} + (65'd2 << size_i[i]);
    assign hit_vec_o[i] = en_i[i] && (addr_i >= base_i[i]) && ({1'b0, addr_i} < lim);
  end
endmodule

// File: rtl/win_prio.sv
module win_prio
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '1;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [6:0]        reg_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic              dis_i,
  input  logic [4:0]        dis_idx_i,
  input  logic [63:0]       lk_addr_i,
  output logic              hit_o,
  output logic [4:0]        idx_o,
  output logic [7:0]        target_o,
  output logic [63:0]       base_o,
  output logic [5:0]        size_o,
  output logic [31:0]       used_o
);
  logic [NUM_WIN-1:0][63:0]      base_w;
  logic [NUM_WIN-1:0]            en_w;
  logic [NUM_WIN-1:0][TGT_W-1:0] tgt_w;
  logic [NUM_WIN-1:0][SZ_W-1:0]  size_w;
  logic [NUM_WIN-1:0]            hit_vec;
  logic                          found;
  logic [IDX_W-1:0]              win_idx;

  win_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .reg_addr_i, .wr_data_i, .rd_data_o,
    .dis_i, .dis_idx_i,
    .base_o(base_w), .en_o(en_w), .tgt_o(tgt_w), .size_o(size_w)
  );

  win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_i(lk_addr_i), .base_i(base_w), .en_i(en_w), .size_i(size_w),
    .hit_vec_o(hit_vec)
  );

  win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .req_i(hit_vec), .found_o(found), .idx_o(win_idx)
  );

  always_comb begin
    target_o = '0;
    base_o   = '0;
    size_o   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (found && win_idx == IDX_W'(i)) begin
        target_o = tgt_w[i];
        base_o   = base_w[i];
        size_o   = size_w[i];
      end
    end
  end

  assign hit_o = found;
  assign idx_o = win_idx;

  for (genvar i = 0; i < MAX_WIN; i++) begin : g_used
    if (i < NUM_WIN) begin : g_live
      assign used_o[i] = en_w[i];
    end else begin : g_absent
      assign used_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/addr_win_dec_chk.sv
module addr_win_dec_chk #(
  parameter int NUM_WIN = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [6:0]  reg_addr_i,
  input logic        wr_en_bit_i,
  input logic        dis_i,
  input logic [4:0]  dis_idx_i,
  input logic [63:0] lk_addr_i,
  input logic        hit_i,
  input logic [4:0]  idx_i,
  input logic [7:0]  target_i,
  input logic [63:0] base_i,
  input logic [5:0]  size_i,
  input logic [31:0] used_i
);
  initial begin
    a_r10_num_win_range: assert (NUM_WIN >= 1 && NUM_WIN <= 32);
  end

  // R8
  a_r8_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> (idx_i == 5'h1f && target_i == 8'h00 && base_i == 64'h0 && size_i == 6'h0));

  // R3
  a_r3_hit_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> used_i[idx_i]);

  // R5
  a_r5_hit_above_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (lk_addr_i >= base_i));

  // R9
  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && dis_idx_i < NUM_WIN) |=> !used_i[$past(dis_idx_i)]);

  // R2, R10
  a_r2_attr_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_addr_i[1:0] == 2'd2 && reg_addr_i[6:2] < NUM_WIN &&
     !(dis_i && dis_idx_i == reg_addr_i[6:2]))
    |=> used_i[$past(reg_addr_i[6:2])] == $past(wr_en_bit_i));
endmodule

bind addr_win_dec addr_win_dec_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .reg_addr_i(reg_addr_i),
  .wr_en_bit_i(wr_data_i[31]), .dis_i(dis_i), .dis_idx_i(dis_idx_i),
  .lk_addr_i(lk_addr_i), .hit_i(hit_o), .idx_i(idx_o), .target_i(target_o),
  .base_i(base_o), .size_i(size_o), .used_i(used_o)
);

// File: tb/addr_win_dec_test.sv
`timescale 1ns/1ps
module addr_win_dec_test;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        dis_i = 1'b0;
  logic [4:0]  dis_idx_i = '0;
  logic [63:0] lk_addr_i = '0;
  logic        hit_o;
  logic [4:0]  idx_o;
  logic [7:0]  target_o;
  logic [63:0] base_o;
  logic [5:0]  size_o;
  logic [31:0] used_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_hi [32];
  logic [31:0] m_lo [32];
  logic [31:0] m_attr [32];

  always #2.5 clk = ~clk;

  addr_win_dec #(.NUM_WIN(NW)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .reg_addr_i, .wr_data_i, .rd_data_o,
    .dis_i, .dis_idx_i, .lk_addr_i, .hit_o, .idx_o, .target_o, .base_o,
    .size_o, .used_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_used();
    logic [31:0] u = '1;
    for (int i = 0; i < NW; i++) u[i] = m_attr[i][31];
    return u;
  endfunction

  task automatic wr(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = 7'(idx * 4 + sel);
    wr_data_i = d;
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (idx < NW) begin
      if (sel == 0) m_hi[idx] = d;
      else if (sel == 1) m_lo[idx] = d;
      else if (sel == 2) m_attr[idx] = d;
    end
  endtask

  task automatic set_win(input int idx, input logic [63:0] b, input logic [31:0] a);
    wr(idx, 0, b[63:32]);
    wr(idx, 1, b[31:0]);
    wr(idx, 2, a);
  endtask

  function automatic logic [31:0] mk_attr(input bit en, input logic [7:0] t, input logic [5:0] s);
    return {en, 3'b000, t, 14'h0, s};
  endfunction

  task automatic dis(input int idx);
    @(negedge clk);
    dis_idx_i = 5'(idx);
    dis_i = 1'b1;
    @(negedge clk);
    dis_i = 1'b0;
    if (idx < NW) begin m_hi[idx] = 0; m_lo[idx] = 0; m_attr[idx] = 0; end
  endtask

  task automatic rd_chk(input string req, input int idx, input int sel);
    logic [31:0] e;
    @(negedge clk);
    reg_addr_i = 7'(idx * 4 + sel);
    #1;
    e = '0;
    if (idx < NW) begin
      if (sel == 0) e = m_hi[idx];
      else if (sel == 1) e = m_lo[idx];
      else if (sel == 2) e = m_attr[idx];
    end
    chk(req, 64'(rd_data_o), 64'(e));
  endtask

  task automatic look(input string req, input logic [63:0] a);
    logic e_hit; logic [4:0] e_idx; logic [7:0] e_tgt; logic [63:0] e_base; logic [5:0] e_sz;
    logic [63:0] b; logic [64:0] top;
    @(negedge clk);
    lk_addr_i = a;
    #1;
    e_hit = 0; e_idx = 5'h1f; e_tgt = 0; e_base = 0; e_sz = 0;
    for (int i = NW - 1; i >= 0; i--) begin
      b = {m_hi[i], m_lo[i]};
      top = 65'(b) + (65'd1 << (m_attr[i][5:0] + 1));
      if (m_attr[i][31] && a >= b && 65'(a) < top) begin
        e_hit = 1; e_idx = 5'(i); e_tgt = m_attr[i][27:20]; e_base = b; e_sz = m_attr[i][5:0];
      end
    end
    chk({req, " hit"}, 64'(hit_o), 64'(e_hit));
    chk({req, " idx"}, 64'(idx_o), 64'(e_idx));
    chk({req, " target"}, 64'(target_o), 64'(e_tgt));
    chk({req, " base"}, base_o, e_base);
    chk({req, " size"}, 64'(size_o), 64'(e_sz));
    chk({req, " used R10"}, 64'(used_o), 64'(exp_used()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    int j;
    for (int i = 0; i < 32; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_attr[i] = 0; end
    void'($urandom(32'd4417));

    // R1: reset state
    repeat (3) @(negedge clk);
    reg_addr_i = 7'd10;
    #1;
    chk("R1 rd", 64'(rd_data_o), 0);
    chk("R1 hit", 64'(hit_o), 0);
    chk("R1 used", 64'(used_o), 64'h0000_0000_ffff_ff00);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: register map, readback, ignored offsets
    set_win(2, 64'h0000_0001_0000_2000, mk_attr(1, addr_win_pkg::TGT_DDR1, 6'd11));
    rd_chk("R2 bhi", 2, 0);
    rd_chk("R2 blo", 2, 1);
    rd_chk("R2 attr", 2, 2);
    wr(2, 3, 32'hdead_beef);
    rd_chk("R2 sel3", 2, 3);
    rd_chk("R2 attr unchanged", 2, 2);
    wr(9, 2, mk_attr(1, 8'h55, 6'd63));
    rd_chk("R2 idx out of range", 9, 2);
    look("R2 out-of-range write ignored", 64'h0);

    // R5 R6 R4: edges of a 4 KiB window above 4 GiB
    look("R5 below base", 64'h0000_0001_0000_1fff);
    look("R6 base", 64'h0000_0001_0000_2000);
    look("R4 last byte", 64'h0000_0001_0000_2fff);
    look("R5 one past", 64'h0000_0001_0000_3000);
    look("R6 low half alone", 64'h0000_0000_0000_2000);

    // R3: disabled lower window is skipped, R7: enabled lower window wins
    set_win(1, 64'h0000_0001_0000_0000, mk_attr(0, addr_win_pkg::TGT_LBUS, 6'd20));
    look("R3 disabled skipped", 64'h0000_0001_0000_2400);
    wr(1, 2, mk_attr(1, addr_win_pkg::TGT_LBUS, 6'd20));
    look("R7 lowest wins", 64'h0000_0001_0000_2400);
    look("R7 only wide", 64'h0000_0001_0001_0000);

    // R5: top of address space and largest size
    set_win(6, 64'hffff_ffff_ffff_f000, mk_attr(1, addr_win_pkg::TGT_SRIO1, 6'd11));
    look("R5 top byte", 64'hffff_ffff_ffff_ffff);
    look("R5 no wrap", 64'h0);
    set_win(7, 64'h0, mk_attr(1, addr_win_pkg::TGT_DDR_IL, 6'd63));
    look("R5 size63 zero", 64'h0);
    look("R7 top prefers 6", 64'hffff_ffff_ffff_fff0);

    // R9: disable clears, disable beats same-cycle write
    dis(6);
    rd_chk("R9 bhi", 6, 0);
    rd_chk("R9 blo", 6, 1);
    rd_chk("R9 attr", 6, 2);
    look("R9 after disable", 64'hffff_ffff_ffff_ffff);
    @(negedge clk);
    reg_addr_i = 7'(7 * 4 + 2); wr_data_i = mk_attr(1, 8'h22, 6'd3); wr_en_i = 1'b1;
    dis_idx_i = 5'd7; dis_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; dis_i = 1'b0;
    m_hi[7] = 0; m_lo[7] = 0; m_attr[7] = 0;
    rd_chk("R9 disable wins", 7, 2);
    look("R8 miss", 64'h0000_0002_0000_0000);

    // random phase over overlapping windows
    for (int n = 0; n < 400; n++) begin
      j = int'($urandom_range(0, NW - 1));
      case ($urandom_range(0, 5))
        0, 1: set_win(j, {32'($urandom_range(0, 1)), 32'($urandom_range(0, 7)) << 12},
                      mk_attr($urandom_range(0, 3) != 0, 8'($urandom), 6'($urandom_range(8, 14))));
        2: dis(j);
        3: rd_chk("R2 random read", j, int'($urandom_range(0, 3)));
        default: ;
      endcase
      a = {m_hi[j], m_lo[j]} + 64'($urandom_range(0, 9000)) - 64'd16;
      look("R7 random", a);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule